// File: doc/BRIEF.md
# Wide-Row Memory with Per-Word Check Codes

This block is a memory whose every row is several 32-bit words wide. Each word in the row keeps its own 7-bit check code, stored in the same physical row as its data. A read fetches the whole row and returns only the word the caller selected. On the way out, that word is checked and, where possible, repaired.

A caller may replace a whole row in one step. It may also replace a single word. Because the storage is one wide row, a single-word write becomes a short sequence: fetch the row, swap in the new word with freshly computed check bits, then write the row back. While any sequence runs, `busy` is high and new requests are dropped.

A fault-injection mask lets the single-word write store a deliberately damaged codeword. This makes the correction path reachable from the ports.

Top module: `wide_ecc_mem`

## Requirements
- R1: A row write (`req_op` = 2) stores eight words. Word k is taken from `req_rowdata[32k+31:32k]`, and each word gets a fresh check code. `busy` is high for exactly one cycle after the accepting edge.
- R2: A read (`req_op` = 0) returns word `req_word` of row `req_row` on `rd_data`. `busy` is high for the two cycles after the accepting edge. `rd_valid` is high for exactly one cycle, on the cycle `busy` falls.
- R3: A word write (`req_op` = 1) replaces only the addressed word of the row and leaves the other seven words unchanged. `busy` is high for three cycles: fetch, merge and write-back.
- R4: Reading a word whose stored codeword is intact returns it with `rd_corrected` = 0 and `rd_uncorrectable` = 0.
- R5: A word write stores its 39-bit codeword XOR `req_flip`. In that codeword, bits 31:0 are data and bits 38:32 are the check code. When exactly one bit is flipped, the read returns the original data with `rd_corrected` = 1.
- R6: When exactly two bits of a stored codeword are flipped, the read sets `rd_uncorrectable` = 1 and `rd_corrected` = 0.
- R7: A request presented while `busy` is high is ignored. It does not change the row being written.
- R8: Opcode 3 is a no-operation. It raises neither `busy` nor `rd_valid`.
- R9: After reset, `busy`, `rd_valid`, `rd_data` and both flags are 0.
- R10: The two error flags are never high together, and neither is high without `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 word write, 2 row write, 3 no-op |
| req_row | input | 4 | Row address |
| req_word | input | 3 | Word index within the row |
| req_wdata | input | 32 | Data for a word write |
| req_rowdata | input | 256 | Data for a row write, word k at bits 32k+31:32k |
| req_flip | input | 39 | Codeword bits to invert on a word write |
| busy | output | 1 | A sequence is in progress |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 32 | Read word after correction |
| rd_corrected | output | 1 | A single-bit error was repaired |
| rd_uncorrectable | output | 1 | A double-bit error was detected |

## Verification
The write-back of a merged row can coincide with a new request. In that cycle, the bench starts a word write and keeps `req_valid` high throughout `busy`, presenting a row write to the same row with different data. Afterwards, every word of that row is read back. Only the single merged word may differ from the earlier contents.

Check-code correction and the merge of neighbouring words are also exercised together. Each of the 39 codeword bits is flipped in turn by a word write. The bench then reads both the damaged word and its untouched neighbour, and judges the flags and data of each against the bench's own model.

// File: rtl/wecc_pkg.sv
package wecc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WWORD = 2'd1,
    OP_WROW  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_RDOUT,
    S_MERGE,
    S_STORE
  } state_e;

  // smallest p with 2^p >= data bits + p + 1
  function automatic int hamm_par_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/wecc_enc.sv
module wecc_enc #(
  parameter int DATA_W = 32,
  localparam int PAR_W = wecc_pkg::hamm_par_bits(DATA_W),
  localparam int NPOS  = DATA_W + PAR_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [PAR_W:0]    chk   // {overall, hamming[PAR_W-1:0]}
);

  logic [PAR_W-1:0] par;

  always_comb begin
    int di;
    di  = 0;
    par = '0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < PAR_W; i++)
          if (((pos >> i) & 1) != 0) par[i] = par[i] ^ data[di];
        di++;
      end
    end
  end

  assign chk = {^{data, par}, par};

endmodule

// File: rtl/wecc_dec.sv
module wecc_dec #(
  parameter int DATA_W = 32,
  localparam int PAR_W = wecc_pkg::hamm_par_bits(DATA_W),
  localparam int CW    = DATA_W + PAR_W + 1,
  localparam int NPOS  = DATA_W + PAR_W
) (
  input  logic [CW-1:0]     cw_in,
  output logic [DATA_W-1:0] data_out,
  output logic              corrected,
  output logic              uncorrectable
);

  logic [DATA_W-1:0] rx_data;
  logic [PAR_W-1:0]  rx_par;
  logic              rx_ovp;
  logic [PAR_W:0]    re_chk;
  logic [PAR_W-1:0]  syn;
  logic              ov_err;
  logic [DATA_W-1:0] fix;

  assign rx_data = cw_in[DATA_W-1:0];
  assign rx_par  = cw_in[DATA_W +: PAR_W];
  assign rx_ovp  = cw_in[CW-1];

  wecc_enc #(.DATA_W(DATA_W)) u_reenc (.data(rx_data), .chk(re_chk));

  assign syn = re_chk[PAR_W-1:0] ^ rx_par;
  // parity over the received bits, derived from the recomputed code
  assign ov_err = re_chk[PAR_W] ^ (^syn) ^ rx_ovp;

  always_comb begin
    int di;
    di  = 0;
    fix = '0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (int'(syn) == pos) fix[di] = 1'b1;
        di++;
      end
    end
  end

  assign corrected     = ov_err;
  assign uncorrectable = !ov_err && (syn != '0);
  assign data_out      = ov_err ? (rx_data ^ fix) : rx_data;

endmodule

// File: rtl/wecc_row_ram.sv
module wecc_row_ram #(
  parameter int ROWS  = 16,
  parameter int WIDTH = 312,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wide_ecc_mem.sv
module wide_ecc_mem #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int ROWS   = 16,
  localparam int PAR_W = wecc_pkg::hamm_par_bits(WORD_W),
  localparam int CW    = WORD_W + PAR_W + 1,
  localparam int ROW_W = WORD_W * WORDS,
  localparam int MEM_W = CW * WORDS,
  localparam int AW    = $clog2(ROWS),
  localparam int SW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_row,
  input  logic [SW-1:0]     req_word,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [ROW_W-1:0]  req_rowdata,
  input  logic [CW-1:0]     req_flip,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable
);
  import wecc_pkg::*;

  state_e            state;
  op_e               op_in, op_q;
  logic              accept;
  logic [AW-1:0]     row_q;
  logic [SW-1:0]     word_q;
  logic [WORD_W-1:0] wdata_q;
  logic [CW-1:0]     flip_q;
  logic [MEM_W-1:0]  wb_q, ram_rdata, merged, enc_row;
  logic [PAR_W:0]    w_chk;
  logic [WORD_W-1:0] dec_data;
  logic              dec_corr, dec_unc;

  assign op_in  = op_e'(req_op);
  assign accept = req_valid && (state == S_IDLE) && (op_in != OP_NONE);
  assign busy   = (state != S_IDLE);

  // full-row path: every word encoded in parallel, no fetch
  for (genvar g = 0; g < WORDS; g++) begin : g_row_enc
    logic [PAR_W:0] c;
    wecc_enc #(.DATA_W(WORD_W)) u_enc (
      .data(req_rowdata[g*WORD_W +: WORD_W]), .chk(c));
    assign enc_row[g*CW +: CW] = {c, req_rowdata[g*WORD_W +: WORD_W]};
  end

  wecc_enc #(.DATA_W(WORD_W)) u_wenc (.data(wdata_q), .chk(w_chk));

  always_comb begin
    merged = ram_rdata;
    merged[word_q*CW +: CW] = {w_chk, wdata_q} ^ flip_q;
  end

  wecc_dec #(.DATA_W(WORD_W)) u_dec (
    .cw_in(ram_rdata[word_q*CW +: CW]),
    .data_out(dec_data), .corrected(dec_corr), .uncorrectable(dec_unc));

  wecc_row_ram #(.ROWS(ROWS), .WIDTH(MEM_W)) u_ram (
    .clk(clk), .we(state == S_STORE), .waddr(row_q), .wdata(wb_q),
    .re(state == S_FETCH), .raddr(row_q), .rdata(ram_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_q    <= OP_READ;
      row_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      flip_q  <= '0;
      wb_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= op_in;
          row_q   <= req_row;
          word_q  <= req_word;
          wdata_q <= req_wdata;
          flip_q  <= req_flip;
          if (op_in == OP_WROW) begin
            wb_q  <= enc_row;
            state <= S_STORE;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= (op_q == OP_READ) ? S_RDOUT : S_MERGE;
        S_RDOUT: state <= S_IDLE;
        S_MERGE: begin
          wb_q  <= merged;
          state <= S_STORE;
        end
        S_STORE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      rd_corrected     <= 1'b0;
      rd_uncorrectable <= 1'b0;
    end else begin
      rd_valid <= (state == S_RDOUT);
      if (state == S_RDOUT) begin
        rd_data          <= dec_data;
        rd_corrected     <= dec_corr;
        rd_uncorrectable <= dec_unc;
      end else begin
        rd_corrected     <= 1'b0;
        rd_uncorrectable <= 1'b0;
      end
    end
  end

  // R1: row write holds busy for one cycle
  a_r1_row_busy: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == OP_WROW) |=> busy ##1 !busy);

  // R2: read result two cycles after acceptance
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == OP_READ) |=> (busy && !rd_valid) ##1 (busy && !rd_valid) ##1 (rd_valid && !busy));

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R3: word write holds busy for three cycles
  a_r3_write_busy: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == OP_WWORD) |=> busy ##1 busy ##1 busy ##1 !busy);

  // R7: target row cannot change while a sequence runs
  a_r7_row_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(row_q));

  // R8: no-op opcode never starts a sequence
  a_r8_nop_idle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && op_in == OP_NONE) |=> !busy);

  // R10: flags exclusive and only alongside rd_valid
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_corrected && rd_uncorrectable));

  a_r10_flags_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_corrected || rd_uncorrectable) |-> rd_valid);

endmodule

// File: tb/wide_ecc_mem_test.sv
`timescale 1ns/1ps
module wide_ecc_mem_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [1:0]   req_op = 2'd0;
  logic [3:0]   req_row = '0;
  logic [2:0]   req_word = '0;
  logic [31:0]  req_wdata = '0;
  logic [255:0] req_rowdata = '0;
  logic [38:0]  req_flip = '0;
  logic         busy, rd_valid, rd_corrected, rd_uncorrectable;
  logic [31:0]  rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [16][8];

  always #5 clk = ~clk;

  wide_ecc_mem uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_word(req_word), .req_wdata(req_wdata),
    .req_rowdata(req_rowdata), .req_flip(req_flip), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
    .rd_uncorrectable(rd_uncorrectable));

  function automatic logic [31:0] pat(input int r, input int w, input int s);
    logic [31:0] a;
    a = 32'(r * 8 + w + 1);
    return (a * 32'h9E3779B1) ^ (32'(s) * 32'h01010101);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request for one edge; return busy cycles and the final outputs
  task automatic issue(input logic [1:0] op, input int r, input int w,
                       input logic [31:0] wd, input logic [255:0] rdat,
                       input logic [38:0] fl, output int bcnt, output logic v,
                       output logic [31:0] d, output logic c, output logic u);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_row = 4'(r); req_word = 3'(w);
    req_wdata = wd; req_rowdata = rdat; req_flip = fl;
    @(negedge clk);
    req_valid = 1'b0;
    bcnt = 0;
    while (busy && bcnt < 20) begin
      bcnt++;
      @(negedge clk);
    end
    v = rd_valid; d = rd_data; c = rd_corrected; u = rd_uncorrectable;
  endtask

  task automatic row_write(input int r, input int s);
    logic [255:0] rdat;
    int b; logic v, c, u; logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rdat[k*32 +: 32] = pat(r, k, s);
      model[r][k] = pat(r, k, s);
    end
    issue(2'd2, r, 0, '0, rdat, '0, b, v, d, c, u);
    check("R1 row write busy cycles", 64'(b), 64'd1);
  endtask

  task automatic word_write(input int r, input int w, input logic [31:0] wd,
                            input logic [38:0] fl);
    int b; logic v, c, u; logic [31:0] d;
    issue(2'd1, r, w, wd, '0, fl, b, v, d, c, u);
    model[r][w] = wd;
    check("R3 word write busy cycles", 64'(b), 64'd3);
  endtask

  task automatic read_chk(input int r, input int w, input bit cmp_data,
                          input logic ec, input logic eu, input string tag);
    int b; logic v, c, u; logic [31:0] d;
    issue(2'd0, r, w, '0, '0, '0, b, v, d, c, u);
    check("R2 read busy cycles", 64'(b), 64'd2);
    check("R2 rd_valid on busy fall", 64'(v), 64'd1);
    if (cmp_data) check(tag, 64'(d), 64'(model[r][w]));
    check({tag, " corrected flag"}, 64'(c), 64'(ec));
    check({tag, " uncorrectable flag"}, 64'(u), 64'(eu));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 busy after reset", 64'(busy), 64'd0);
    check("R9 rd_valid after reset", 64'(rd_valid), 64'd0);
    check("R9 rd_data after reset", 64'(rd_data), 64'd0);
    check("R9 flags after reset", 64'({rd_corrected, rd_uncorrectable}), 64'd0);

    // R1 fill every row, R2/R4 sweep every word
    for (int r = 0; r < 16; r++) row_write(r, 0);
    for (int r = 0; r < 16; r++)
      for (int w = 0; w < 8; w++) read_chk(r, w, 1, 1'b0, 1'b0, "R2 R4 clean read");

    // R3 merge keeps neighbours
    for (int r = 0; r < 4; r++) begin
      word_write(r, (r * 2 + 1) % 8, pat(r, 9, 77), '0);
      for (int w = 0; w < 8; w++) read_chk(r, w, 1, 1'b0, 1'b0, "R3 merged row");
    end

    // R5 every single-bit flip is repaired; neighbour stays clean
    for (int bit_i = 0; bit_i < 39; bit_i++) begin
      int r, w;
      r = bit_i % 16; w = bit_i % 8;
      word_write(r, w, pat(r, w, bit_i + 3), 39'(1) << bit_i);
      read_chk(r, w, 1, 1'b1, 1'b0, "R5 single flip");
      read_chk(r, w ^ 1, 1, 1'b0, 1'b0, "R4 neighbour of flip");
    end

    // R6 double flips detected
    begin
      int pa [6] = '{0, 5, 31, 32, 12, 37};
      int pb [6] = '{1, 33, 38, 37, 20, 38};
      for (int k = 0; k < 6; k++) begin
        word_write(15, k, pat(15, k, 200 + k), (39'(1) << pa[k]) | (39'(1) << pb[k]));
        read_chk(15, k, 0, 1'b0, 1'b1, "R6 double flip");
      end
    end

    // R7 requests held during a word write are ignored
    row_write(2, 5);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_row = 4'd2; req_word = 3'd4;
    req_wdata = 32'hC0DE_1234; req_flip = '0; req_rowdata = '0;
    @(negedge clk);
    req_op = 2'd2;
    for (int k = 0; k < 8; k++) req_rowdata[k*32 +: 32] = 32'hDEAD_0000 + 32'(k);
    while (busy) @(negedge clk);
    req_valid = 1'b0;
    model[2][4] = 32'hC0DE_1234;
    for (int w = 0; w < 8; w++) read_chk(2, w, 1, 1'b0, 1'b0, "R7 row after ignored requests");

    // R8 no-op opcode
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_row = 4'd4; req_word = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 no-op busy", 64'(busy), 64'd0);
    @(negedge clk);
    check("R8 no-op rd_valid", 64'(rd_valid), 64'd0);
    read_chk(4, 0, 1, 1'b0, 1'b0, "R8 read after no-op");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule